// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a missed address translation. It walks a radix tree of page tables that sits in memory and produces a physical page number. A request carries a 48-bit virtual address, the access type (write or read, user or supervisor) and the page number of the top-level table. The walker then reads one 64-bit table entry per level through a single-outstanding read port. Each table occupies one 4 KB page and is indexed by a 9-bit slice of the virtual address.

Every entry is checked for presence. The last entry is also checked against the access type. The walk ends with a one-cycle result pulse. That pulse carries either the physical page number with the entry's attribute bits, or a fault with a cause code and the level that stopped the walk. On a fault, the virtual address is latched into a register that holds its value until the next fault.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` and `res_valid` are 0, and `fault_vaddr` is 0.
- R2: The walk reads the level-0 table at page `root_ppn` and then levels 1, 2 and 3 in that order. Each read address is the table page number times 4096 plus the index times 8. The level-k index is virtual-address bits [47-9k : 39-9k].
- R3: At most one memory read is outstanding at any time. `mem_req_valid` stays high, with a stable address, until `mem_req_ready` is seen.
- R4: `req_ready` is low from the cycle after a request is accepted until the result pulse. Requests offered during a walk are not taken.
- R5: An entry whose bit 0 (present) is 0, at any level, ends the walk with a fault. No further reads are issued. `res_level` gives the level (0 to 3).
- R6: Only on the level-3 entry, a write is a protection fault when bit 1 (writable) is 0, and a user access is a protection fault when bit 2 (user) is 0. Bits 1 and 2 of levels 0 to 2 have no effect.
- R7: On success, `res_ppn` equals entry bits 47:12 of the level-3 entry. `res_flags` is {bit 6 dirty, bit 5 accessed, bit 2 user, bit 1 writable}. Entry bits 63:48 are ignored, and each next table is taken from bits 47:12.
- R8: `res_cause` bit 0 is 1 for a protection fault and 0 for a not-present fault. Bit 1 copies the request's write flag. A protection fault is reported only at level 3.
- R9: On a fault, `fault_vaddr` takes the request's virtual address. On a successful walk, it keeps its previous value.
- R10: Each accepted request produces exactly one single-cycle `res_valid` pulse, issued after the last read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_ppn | input | PPN_W | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | PTE_W | Table entry |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_cause | output | 2 | {write access, protection} |
| res_level | output | LVL_W | Level of the last entry read |
| res_ppn | output | PPN_W | Translated physical page number |
| res_flags | output | 4 | {dirty, accessed, user, writable} |
| fault_vaddr | output | VA_W | Virtual address of the last fault |

## Verification
The bench builds the walker with its defaults: 48-bit virtual and physical addresses, 9-bit indices, a 12-bit offset, four levels and 64-bit entries. At these values the top index reaches virtual-address bit 47 and the page number reaches entry bit 47. A bench with all-ones addresses and page numbers can therefore show that no slice is off by one and that the upper entry bits are dropped. A memory model with random accept and response delays exercises the held request. Random table contents reach not-present faults at every level and all four cause codes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [1:0] {
      WK_IDLE,
      WK_ISSUE,
      WK_AWAIT
   } walk_state_e;

   // entry attribute bit positions
   localparam int unsigned ENT_PRESENT  = 0;
   localparam int unsigned ENT_WRITABLE = 1;
   localparam int unsigned ENT_USER     = 2;
   localparam int unsigned ENT_ACCESSED = 5;
   localparam int unsigned ENT_DIRTY    = 6;

   // cause code bit positions
   localparam int unsigned CAUSE_PROT  = 0;
   localparam int unsigned CAUSE_WRITE = 1;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int VA_W   = 48,
   parameter int PA_W   = 48,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12,
   parameter int LEVELS = 4,
   parameter int PTE_W  = 64,
   localparam int PPN_W = PA_W - OFF_W,
   localparam int LVL_W = $clog2(LEVELS),
   localparam int SH    = $clog2(PTE_W / 8)
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] lvl,
   input  logic [PPN_W-1:0] tbl_ppn,
   output logic [PA_W-1:0]  ent_addr
);
   logic [IDX_W-1:0] idx_arr [LEVELS];
   logic [IDX_W-1:0] sel_idx;
   logic [OFF_W-1:0] byte_off;
   logic             unused_off;

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_idx
         assign idx_arr[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
      end
   endgenerate

   assign unused_off = ^vaddr[OFF_W-1:0];
   assign sel_idx    = idx_arr[lvl];
   assign byte_off   = OFF_W'({sel_idx, {SH{1'b0}}});
   assign ent_addr   = {tbl_ppn, byte_off};
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
   import ptw_pkg::*;
#(
   parameter int PA_W  = 48,
   parameter int OFF_W = 12,
   parameter int PTE_W = 64,
   localparam int PPN_W = PA_W - OFF_W
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             is_leaf,
   input  logic             acc_write,
   input  logic             acc_user,
   output logic             present,
   output logic             prot_err,
   output logic [PPN_W-1:0] next_ppn,
   output logic [3:0]       flags
);
   logic wr_deny;
   logic us_deny;
   logic unused_bits;

   assign present  = pte[ENT_PRESENT];
   assign next_ppn = pte[PA_W-1:OFF_W];
   assign flags    = {pte[ENT_DIRTY], pte[ENT_ACCESSED], pte[ENT_USER], pte[ENT_WRITABLE]};
   assign wr_deny  = acc_write && !pte[ENT_WRITABLE];
   assign us_deny  = acc_user && !pte[ENT_USER];
   assign prot_err = is_leaf && present && (wr_deny || us_deny);

   assign unused_bits = ^{pte[PTE_W-1:PA_W], pte[OFF_W-1:7], pte[4:3]};
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W   = 48,
   parameter int PA_W   = 48,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12,
   parameter int LEVELS = 4,
   parameter int PTE_W  = 64,
   localparam int PPN_W = PA_W - OFF_W,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic             req_user,
   input  logic [PPN_W-1:0] root_ppn,
   output logic             mem_req_valid,
   input  logic             mem_req_ready,
   output logic [PA_W-1:0]  mem_req_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             res_valid,
   output logic             res_fault,
   output logic [1:0]       res_cause,
   output logic [LVL_W-1:0] res_level,
   output logic [PPN_W-1:0] res_ppn,
   output logic [3:0]       res_flags,
   output logic [VA_W-1:0]  fault_vaddr
);
   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   // elaboration-time parameter checks
   generate
      if (VA_W != LEVELS*IDX_W + OFF_W) begin : g_bad_va
         $error("VA_W must equal LEVELS*IDX_W+OFF_W");
      end
      if (LEVELS < 2) begin : g_bad_lvl
         $error("LEVELS must be at least 2");
      end
      if (IDX_W + $clog2(PTE_W/8) != OFF_W) begin : g_bad_tbl
         $error("a table must fill exactly one page");
      end
      if (PA_W >= PTE_W || PA_W <= OFF_W) begin : g_bad_pa
         $error("PA_W must lie between OFF_W and PTE_W");
      end
      if (PTE_W % 8 != 0 || PTE_W < 16) begin : g_bad_pte
         $error("PTE_W must be a whole number of bytes");
      end
   endgenerate

   walk_state_e      state_q;
   logic [LVL_W-1:0] lvl_q;
   logic [VA_W-1:0]  va_q;
   logic             wr_q;
   logic             us_q;
   logic [PPN_W-1:0] tbl_q;

   logic             ent_present;
   logic             ent_prot;
   logic [PPN_W-1:0] ent_ppn;
   logic [3:0]       ent_flags;
   logic             at_leaf;

   assign at_leaf       = (lvl_q == LAST_LVL);
   assign req_ready     = (state_q == WK_IDLE);
   assign mem_req_valid = (state_q == WK_ISSUE);

   ptw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W),
      .OFF_W(OFF_W), .LEVELS(LEVELS), .PTE_W(PTE_W)
   ) u_addr (
      .vaddr    (va_q),
      .lvl      (lvl_q),
      .tbl_ppn  (tbl_q),
      .ent_addr (mem_req_addr)
   );

   ptw_pte_check #(
      .PA_W(PA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)
   ) u_chk_ent (
      .pte       (mem_rsp_data),
      .is_leaf   (at_leaf),
      .acc_write (wr_q),
      .acc_user  (us_q),
      .present   (ent_present),
      .prot_err  (ent_prot),
      .next_ppn  (ent_ppn),
      .flags     (ent_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= WK_IDLE;
         lvl_q       <= '0;
         va_q        <= '0;
         wr_q        <= 1'b0;
         us_q        <= 1'b0;
         tbl_q       <= '0;
         res_valid   <= 1'b0;
         res_fault   <= 1'b0;
         res_cause   <= '0;
         res_level   <= '0;
         res_ppn     <= '0;
         res_flags   <= '0;
         fault_vaddr <= '0;
      end else begin
         res_valid <= 1'b0;
         unique case (state_q)
            WK_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  us_q    <= req_user;
                  tbl_q   <= root_ppn;
                  lvl_q   <= '0;
                  state_q <= WK_ISSUE;
               end
            end
            WK_ISSUE: begin
               if (mem_req_ready) begin
                  state_q <= WK_AWAIT;
               end
            end
            WK_AWAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_present || ent_prot) begin
                     res_valid   <= 1'b1;
                     res_fault   <= 1'b1;
                     res_cause   <= {wr_q, ent_present};
                     res_level   <= lvl_q;
                     res_ppn     <= '0;
                     res_flags   <= '0;
                     fault_vaddr <= va_q;
                     state_q     <= WK_IDLE;
                  end else if (at_leaf) begin
                     res_valid <= 1'b1;
                     res_fault <= 1'b0;
                     res_cause <= '0;
                     res_level <= lvl_q;
                     res_ppn   <= ent_ppn;
                     res_flags <= ent_flags;
                     state_q   <= WK_IDLE;
                  end else begin
                     tbl_q   <= ent_ppn;
                     lvl_q   <= lvl_q + 1'b1;
                     state_q <= WK_ISSUE;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W   = 48,
   parameter int PA_W   = 48,
   parameter int IDX_W  = 9,
   parameter int OFF_W  = 12,
   parameter int LEVELS = 4,
   parameter int PTE_W  = 64,
   localparam int PPN_W = PA_W - OFF_W,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             mem_rsp_valid,
   input logic             res_valid,
   input logic             res_fault,
   input logic [1:0]       res_cause,
   input logic [LVL_W-1:0] res_level,
   input logic [VA_W-1:0]  fault_vaddr
);
   assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   assert_prot_at_leaf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault && res_cause[0] |-> res_level == LVL_W'(LEVELS - 1));

   assert_fault_reg_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_fault |-> $stable(fault_vaddr));

   assert_result_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(mem_rsp_valid));

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
endmodule

bind ptw_walker ptw_walker_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W),
   .OFF_W(OFF_W), .LEVELS(LEVELS), .PTE_W(PTE_W)
) u_walker_chk (.*);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [35:0] root_ppn = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [47:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        res_fault;
   logic [1:0]  res_cause;
   logic [1:0]  res_level;
   logic [35:0] res_ppn;
   logic [3:0]  res_flags;
   logic [47:0] fault_vaddr;

   int tests = 0;
   int fails = 0;
   int reads = 0;
   logic [63:0] pmem [logic [47:0]];
   logic [47:0] last_fault = '0;

   always #5 clk = ~clk;

   ptw_walker u0 (.*);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: random accept and response delay, one read at a time
   initial begin
      bit pend = 0;
      int dly = 0;
      logic [47:0] a = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend) begin
            if (dly == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pmem.exists(a) ? pmem[a] : 64'h0;
               pend = 0;
            end else dly--;
         end
         mem_req_ready = !pend && ($urandom % 4 != 0);
         if (mem_req_valid && mem_req_ready && rst_n) begin
            pend = 1; dly = $urandom % 3; a = mem_req_addr; reads++;
         end
      end
   end

   function automatic logic [47:0] ent_addr(input logic [35:0] tbl, input logic [47:0] va, input int k);
      logic [8:0] idx = va[47 - 9*k -: 9];
      return {tbl, idx, 3'b000};
   endfunction

   // chain: ppn of table/page pointed to by each level; attr: low 12 bits
   task automatic build(input logic [47:0] va, input logic [35:0] root,
                        input logic [35:0] nxt [4], input logic [11:0] attr [4]);
      logic [35:0] tbl = root;
      pmem.delete();
      for (int k = 0; k < 4; k++) begin
         pmem[ent_addr(tbl, va, k)] = {16'($urandom), nxt[k], attr[k]};
         tbl = nxt[k];
      end
   endtask

   task automatic walk(input logic [47:0] va, input bit wr, input bit us,
                       input logic [35:0] root, input bit hold_busy);
      logic [35:0] tbl = root;
      bit ef = 0; logic [1:0] ec = 0; int el = 0; logic [35:0] ep = 0; logic [3:0] efl = 0;
      int n = 0;
      // reference walk
      for (int k = 0; k < 4; k++) begin
         logic [63:0] p = pmem.exists(ent_addr(tbl, va, k)) ? pmem[ent_addr(tbl, va, k)] : 64'h0;
         el = k;
         if (!p[0]) begin ef = 1; ec = {wr, 1'b0}; break; end
         if (k == 3) begin
            if ((wr && !p[1]) || (us && !p[2])) begin ef = 1; ec = {wr, 1'b1}; end
            else begin ep = p[47:12]; efl = {p[6], p[5], p[2], p[1]}; end
         end
         tbl = p[47:12];
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      reads = 0;
      req_valid = 1; req_vaddr = va; req_write = wr; req_user = us; root_ppn = root;
      @(negedge clk);
      if (hold_busy) begin
         req_vaddr = ~va; req_write = ~wr; root_ppn = ~root;
      end else req_valid = 0;
      chk(req_ready == 0, "R4 busy after accept", req_ready, 0);
      while (!res_valid && n < 300) begin
         if (hold_busy) chk(req_ready == 0, "R4 busy during walk", req_ready, 0);
         @(negedge clk); n++;
      end
      req_valid = 0;
      if (!res_valid) begin
         chk(0, "R10 no result pulse", 0, 1);
         return;
      end
      chk(res_fault == ef, "R5/R6 fault flag", res_fault, ef);
      chk(reads == el + 1, "R2/R5 read count", reads, el + 1);
      chk(res_level == el[1:0], "R5 level", res_level, el);
      if (ef) begin
         chk(res_cause == ec, "R8 cause", res_cause, ec);
         chk(fault_vaddr == va, "R9 fault address", fault_vaddr, va);
         last_fault = va;
      end else begin
         chk(res_ppn == ep, "R7 ppn", res_ppn, ep);
         chk(res_flags == efl, "R7 flags", res_flags, efl);
         chk(fault_vaddr == last_fault, "R9 kept on success", fault_vaddr, last_fault);
      end
      @(negedge clk);
      chk(res_valid == 0, "R10 single pulse", res_valid, 0);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [35:0] nx [4];
      logic [11:0] at [4];
      logic [47:0] va;
      logic [35:0] rt;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1, "R1 ready", req_ready, 1);
      chk(mem_req_valid == 0, "R1 no read", mem_req_valid, 0);
      chk(res_valid == 0, "R1 no result", res_valid, 0);
      chk(fault_vaddr == 0, "R1 fault reg", fault_vaddr, 0);
      rst_n = 1;

      // R2 R7: full permissions, distinct tables
      va = 48'h1234_5678_9ABC; rt = 36'h0_0000_1000;
      nx = '{36'h111, 36'h222, 36'h333, 36'hA_BCDE_F012};
      at = '{12'h007, 12'h007, 12'h007, 12'h067};
      build(va, rt, nx, at);
      walk(va, 1, 1, rt, 0);
      // R5: not present at level 0, then at level 3 (with write: R8 cause 10)
      at = '{12'h006, 12'h007, 12'h007, 12'h007}; build(va, rt, nx, at);
      walk(va, 0, 0, rt, 0);
      at = '{12'h001, 12'h001, 12'h001, 12'h066}; build(va, rt, nx, at);
      walk(va, 1, 0, rt, 0);
      // R6: write to read-only leaf, user to supervisor leaf
      at = '{12'h007, 12'h007, 12'h007, 12'h005}; build(va, rt, nx, at);
      walk(va, 1, 0, rt, 0);
      at = '{12'h007, 12'h007, 12'h007, 12'h003}; build(va, rt, nx, at);
      walk(va, 0, 1, rt, 0);
      // R6: intermediate read-only supervisor entries ignored; R9 kept
      at = '{12'h001, 12'h001, 12'h001, 12'h027}; build(va, rt, nx, at);
      walk(va, 1, 1, rt, 0);
      // R2 R7 boundary: all-ones address, page numbers and upper bits
      va = '1; rt = '1;
      nx = '{36'hF_FFFF_FFFF, 36'hF_FFFF_FFFE, 36'h0, 36'hF_FFFF_FFFF};
      at = '{12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF}; build(va, rt, nx, at);
      walk(va, 1, 1, rt, 0);
      // R4: request held high through a walk is not taken
      va = 48'h0000_0040_3000; rt = 36'h5;
      nx = '{36'h9, 36'hA, 36'hB, 36'hC};
      at = '{12'h001, 12'h001, 12'h001, 12'h023}; build(va, rt, nx, at);
      walk(va, 0, 0, rt, 1);
      walk(va, 0, 0, rt, 0);

      // constrained random
      void'($urandom(32'hC0FFEE));
      for (int t = 0; t < 80; t++) begin
         va = {$urandom, $urandom};
         rt = 36'({$urandom, $urandom});
         for (int k = 0; k < 4; k++) begin
            nx[k] = 36'({$urandom, $urandom});
            at[k] = 12'($urandom);
            at[k][0] = ($urandom % 8 != 0);
         end
         build(va, rt, nx, at);
         walk(va, 1'($urandom), 1'($urandom), rt, ($urandom % 5 == 0));
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule